// File: doc/BRIEF.md
# Asynchronous DRAM Device-Side Emulator

This block stands in for an asynchronous DRAM part on the device side of the pins. A fast internal clock samples the active-low row strobe, column strobe, write enable, output enable and the shared address bus. Edges found on the strobes drive a small register-based cell array. A row strobe fall latches a row and opens it. Each column strobe fall inside an open row then reads or writes one cell.

The block also decodes the strobe orderings a real part responds to. If the column strobe is already low when the row strobe falls, the block performs a refresh: the address pins are ignored and an internal counter picks the row. Read data uses extended-data-out behaviour, so it stays on the pins after the column strobe rises. A hidden refresh can run under a held read. An optional nibble mode makes the block step the column itself on the later strobes of a group. An illegal strobe order raises a sticky error flag.

Top module: `async_dram_emu`

## Requirements
- R1: After reset, `dout_en` is 0, `cbr_count` is 0, `rfsh_row` is 0 and `err_flag` is 0.
- R2: A row strobe fall, with the column strobe high just before it, opens the row given by the low row-index bits of `addr`. A column strobe fall in that open row with `we_n` low stores `din` at (row, column), where the column is the low column-index bits of `addr`.
- R3: A column strobe fall in an open row with `we_n` high reads the addressed cell onto `dout`. `dout_en` is 1 only while a read result is held and the sampled `oe_n` is low. A write strobe clears the held result.
- R4: A row strobe fall while the column strobe is already low is a refresh. It ignores `addr` and uses the internal counter as the row. It reports that row on `rfsh_row` and adds 1 to `cbr_count`. The counter then advances and wraps from ROWS-1 to 0. Cell contents are unchanged.
- R5: Read data stays valid while the row stays open after the column strobe rises. It is withdrawn when the row strobe rises while the column strobe is high.
- R6: A row strobe rise while the column strobe is held low keeps the read data driven. A following row strobe fall is a refresh per R4 and leaves `dout` and `dout_en` unchanged. The data is withdrawn when the column strobe later rises while the row strobe is high.
- R7: With `nibble_en` high, the first column strobe in a row uses `addr`. The second to fourth strobes ignore `addr` and add 1 to the low two column bits, wrapping inside the aligned group of four while the upper column bits are kept. The fifth strobe takes `addr` again. With `nibble_en` low, every strobe uses `addr`.
- R8: `err_flag` is set, and stays set until reset, when the column strobe falls while a refresh row is open. It is also set when `we_n` or `addr` is unknown at an access strobe. It stays 0 under legal strobe orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, taken at the column strobe fall |
| oe_n | input | 1 | Output enable, active low |
| nibble_en | input | 1 | Enables internal column stepping |
| addr | input | ADDR_W | Shared row/column address |
| din | input | DW | Write data |
| dout | output | DW | Held read data |
| dout_en | output | 1 | High while `dout` is driven |
| err_flag | output | 1 | Sticky illegal-order flag |
| cbr_count | output | CNT_W | Number of refreshes performed |
| rfsh_row | output | RW | Row used by the most recent refresh |

## Verification
The delicate overlap is a hidden refresh: in a single evaluation cycle the refresh counter steps while the extended-data-out hold keeps the earlier read result on the pins. The bench provokes it in three steps. It opens a row and reads a cell, then raises the row strobe with the column strobe still low, then lowers the row strobe again. It then requires `cbr_count` and `rfsh_row` to advance while `dout` and `dout_en` keep their values. A final column strobe rise must withdraw the data. Around this case, exhaustive page-mode write and read sweeps over every cell, a counter wrap, and nibble stepping are each checked against values the bench computes from the requirements.

// File: rtl/adram_pkg.sv
package adram_pkg;

    // Edge strobes decoded from the sampled pins
    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
    } strobe_t;

    function automatic int unsigned wmax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Next column inside an aligned group of four
    function automatic logic [1:0] nib_step(logic [1:0] lo);
        return lo + 2'd1;
    endfunction

endpackage

// File: rtl/adram_pin_sampler.sv
module adram_pin_sampler #(
    parameter int ADDR_W = 4,
    parameter int DW     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DW-1:0]         din,
    output adram_pkg::strobe_t    stb,
    output logic                  ras_lo,
    output logic                  cas_lo,
    output logic                  cas_was_low,
    output logic                  we_s,
    output logic                  oe_s,
    output logic [ADDR_W-1:0]     addr_s,
    output logic [DW-1:0]         din_s,
    output logic                  pins_x
);
    typedef struct packed {
        logic              ras;
        logic              cas;
        logic              we;
        logic              oe;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     din;
    } pins_t;

    typedef struct packed {
        pins_t cur;
        logic  ras_prev;
        logic  cas_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.cur      = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n, addr: addr, din: din};
        smp_d.ras_prev = smp_q.cur.ras;
        smp_d.cas_prev = smp_q.cur.cas;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '{cur: '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1, addr: '0, din: '0},
                       ras_prev: 1'b1, cas_prev: 1'b1};
        end else begin
            smp_q <= smp_d;
        end
    end

    assign stb.ras_fall = smp_q.ras_prev  & ~smp_q.cur.ras;
    assign stb.ras_rise = ~smp_q.ras_prev & smp_q.cur.ras;
    assign stb.cas_fall = smp_q.cas_prev  & ~smp_q.cur.cas;
    assign stb.cas_rise = ~smp_q.cas_prev & smp_q.cur.cas;
    assign ras_lo       = ~smp_q.cur.ras;
    assign cas_lo       = ~smp_q.cur.cas;
    assign cas_was_low  = ~smp_q.cas_prev;
    assign we_s         = smp_q.cur.we;
    assign oe_s         = smp_q.cur.oe;
    assign addr_s       = smp_q.cur.addr;
    assign din_s        = smp_q.cur.din;
    assign pins_x       = $isunknown({smp_q.cur.we, smp_q.cur.addr});
endmodule

// File: rtl/adram_cell_array.sv
module adram_cell_array #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 4
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [$clog2(ROWS)-1:0]   wr_row,
    input  logic [$clog2(COLS)-1:0]   wr_col,
    input  logic [DW-1:0]             wr_data,
    input  logic [$clog2(ROWS)-1:0]   rd_row,
    input  logic [$clog2(COLS)-1:0]   rd_col,
    output logic [DW-1:0]             rd_data
);
    localparam int RW    = $clog2(ROWS);
    localparam int CW    = $clog2(COLS);
    localparam int CELLS = ROWS * COLS;

    logic [DW-1:0] cell_q [CELLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cell_q[{wr_row, wr_col}] <= wr_data;
        end
    end

    assign rd_data = cell_q[{rd_row, rd_col}];
endmodule

// File: rtl/async_dram_emu.sv
module async_dram_emu #(
    parameter int ROWS   = 16,
    parameter int COLS   = 16,
    parameter int DW     = 4,
    parameter int CNT_W  = 8,
    parameter int RW     = $clog2(ROWS),
    parameter int CW     = $clog2(COLS),
    parameter int ADDR_W = adram_pkg::wmax(RW, CW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              nibble_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_en,
    output logic              err_flag,
    output logic [CNT_W-1:0]  cbr_count,
    output logic [RW-1:0]     rfsh_row
);
    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [CW-1:0] GRP_MASK = ~CW'(3);

    typedef struct packed {
        logic             row_open;
        logic             in_rfsh;
        logic [RW-1:0]    row;
        logic [CW-1:0]    col;
        logic [1:0]       nib;
        logic [DW-1:0]    data;
        logic             valid;
        logic             err;
        logic [RW-1:0]    rctr;
        logic [RW-1:0]    rrow;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    adram_pkg::strobe_t stb;
    logic              ras_lo, cas_lo, cas_was_low, we_s, oe_s, pins_x;
    logic [ADDR_W-1:0] addr_s;
    logic [DW-1:0]     din_s;
    logic [CW-1:0]     col_sel;
    logic              wr_en;
    logic [DW-1:0]     rd_data;

    adram_pin_sampler #(.ADDR_W(ADDR_W), .DW(DW)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .din        (din),
        .stb        (stb),
        .ras_lo     (ras_lo),
        .cas_lo     (cas_lo),
        .cas_was_low(cas_was_low),
        .we_s       (we_s),
        .oe_s       (oe_s),
        .addr_s     (addr_s),
        .din_s      (din_s),
        .pins_x     (pins_x)
    );

    adram_cell_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_arr (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_row (ctl_q.row),
        .wr_col (col_sel),
        .wr_data(din_s),
        .rd_row (ctl_q.row),
        .rd_col (col_sel),
        .rd_data(rd_data)
    );

    // Column for the current strobe: stepped in nibble mode, else from pins
    always_comb begin
        if (nibble_en && (ctl_q.nib != 2'd0)) begin
            col_sel = (ctl_q.col & GRP_MASK) | CW'(adram_pkg::nib_step(ctl_q.col[1:0]));
        end else begin
            col_sel = addr_s[CW-1:0];
        end
    end

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;

        if (stb.ras_fall) begin
            ctl_d.row_open = 1'b1;
            if (cas_was_low) begin
                ctl_d.in_rfsh = 1'b1;
                ctl_d.rrow    = ctl_q.rctr;
                ctl_d.rctr    = (ctl_q.rctr == LAST_ROW) ? '0 : ctl_q.rctr + 1'b1;
                ctl_d.cnt     = ctl_q.cnt + 1'b1;
            end else begin
                ctl_d.in_rfsh = 1'b0;
                ctl_d.row     = addr_s[RW-1:0];
                ctl_d.nib     = 2'd0;
            end
        end

        if (stb.cas_fall && ctl_q.row_open) begin
            if (ctl_q.in_rfsh) begin
                ctl_d.err = 1'b1;
            end else begin
                if (pins_x) begin
                    ctl_d.err = 1'b1;
                end
                ctl_d.col = col_sel;
                ctl_d.nib = nibble_en ? ctl_q.nib + 2'd1 : 2'd0;
                if (!we_s) begin
                    wr_en       = 1'b1;
                    ctl_d.valid = 1'b0;
                end else begin
                    ctl_d.data  = rd_data;
                    ctl_d.valid = 1'b1;
                end
            end
        end

        if (stb.ras_rise) begin
            ctl_d.row_open = 1'b0;
            ctl_d.in_rfsh  = 1'b0;
            if (!cas_lo) begin
                ctl_d.valid = 1'b0;
            end
        end

        if (stb.cas_rise && !ras_lo) begin
            ctl_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dout      = ctl_q.data;
    assign dout_en   = ctl_q.valid & ~oe_s;
    assign err_flag  = ctl_q.err;
    assign cbr_count = ctl_q.cnt;
    assign rfsh_row  = ctl_q.rrow;
endmodule

// File: rtl/adram_checker.sv
module adram_checker #(
    parameter int DW    = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_n,
    input logic             cas_n,
    input logic [DW-1:0]    dout,
    input logic             dout_en,
    input logic             err_flag,
    input logic [CNT_W-1:0] cbr_count
);
    // R3: data is driven only when the enable pin was low at the prior sample
    p_drive_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !$past(oe_n));

    // R4: refresh count moves by exactly one at a time
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_count != $past(cbr_count)) |-> (cbr_count == $past(cbr_count) + 1'b1));

    // R5: held data moves only after a sampled column strobe fall
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cas_n, 2) |-> $stable(dout));

    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) |-> err_flag);
endmodule

bind async_dram_emu adram_checker #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .cas_n    (cas_n),
    .dout     (dout),
    .dout_en  (dout_en),
    .err_flag (err_flag),
    .cbr_count(cbr_count)
);

// File: tb/async_dram_emu_test.sv
module async_dram_emu_test;
    localparam int ROWS = 16;
    localparam int COLS = 16;
    localparam int DW   = 4;
    localparam int CNTW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, nibble_en = 1'b0;
    logic [3:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, err_flag;
    logic [CNTW-1:0] cbr_count;
    logic [3:0] rfsh_row;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] expv [ROWS][COLS];

    always #10 clk = ~clk;

    async_dram_emu uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .nibble_en(nibble_en), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .err_flag(err_flag),
        .cbr_count(cbr_count), .rfsh_row(rfsh_row)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic row_open(input int r);
        addr = 4'(r); ras_n = 1'b0; tick(3);
    endtask

    task automatic row_close();
        ras_n = 1'b1; tick(3);
    endtask

    task automatic cas_low(input int c, input logic wr, input logic [DW-1:0] d);
        addr = 4'(c); we_n = ~wr; din = d; cas_n = 1'b0; tick(3);
    endtask

    task automatic cas_high();
        cas_n = 1'b1; we_n = 1'b1; tick(3);
    endtask

    function automatic int drv(input logic [DW-1:0] d);
        return 16 + int'(d);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int base;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 dout_en", int'(dout_en), 0);
        chk("R1 cbr_count", int'(cbr_count), 0);
        chk("R1 rfsh_row", int'(rfsh_row), 0);
        chk("R1 err_flag", int'(err_flag), 0);

        // R2: page-mode write of every cell
        for (int r = 0; r < ROWS; r++) begin
            row_open(r);
            for (int c = 0; c < COLS; c++) begin
                expv[r][c] = DW'((r * 3 + c * 5 + 1) % 16);
                cas_low(c, 1'b1, expv[r][c]);
                chk("R3 write strobe leaves output off", int'(dout_en), 0);
                cas_high();
            end
            row_close();
        end

        // R2/R3/R5: read sweep with data hold after column strobe rise
        for (int r = 0; r < ROWS; r++) begin
            row_open(r);
            for (int c = 0; c < COLS; c++) begin
                cas_low(c, 1'b0, '0);
                chk("R2 R3 read", {dout_en, dout}, drv(expv[r][c]));
                cas_high();
                chk("R5 data held after cas rise", {dout_en, dout}, drv(expv[r][c]));
            end
            row_close();
            chk("R5 withdrawn on row close", int'(dout_en), 0);
        end

        // R3: output enable gating and write clearing
        row_open(3);
        cas_low(9, 1'b0, '0);
        oe_n = 1'b1; tick(3);
        chk("R3 oe high blocks drive", int'(dout_en), 0);
        oe_n = 1'b0; tick(3);
        chk("R3 oe low drives", {dout_en, dout}, drv(expv[3][9]));
        cas_high();
        expv[3][2] = 4'hA;
        cas_low(2, 1'b1, 4'hA);
        chk("R3 write clears held read", int'(dout_en), 0);
        cas_high();
        cas_low(2, 1'b0, '0);
        chk("R2 written value reads back", {dout_en, dout}, drv(4'hA));
        cas_high();
        row_close();

        // R4: refresh sequence across the wrap
        for (int i = 0; i < ROWS + 2; i++) begin
            addr = 4'd5; cas_n = 1'b0; tick(3);
            ras_n = 1'b0; tick(3);
            chk("R4 refresh count", int'(cbr_count), i + 1);
            chk("R4 refresh row", int'(rfsh_row), i % ROWS);
            chk("R4 no output during refresh", int'(dout_en), 0);
            ras_n = 1'b1; tick(3);
            cas_n = 1'b1; tick(3);
        end
        row_open(0);
        cas_low(5, 1'b0, '0);
        chk("R4 contents kept after refresh", {dout_en, dout}, drv(expv[0][5]));
        cas_high();
        row_close();

        // R6: hidden refresh under a held read
        base = int'(cbr_count);
        row_open(2);
        cas_low(7, 1'b0, '0);
        ras_n = 1'b1; tick(3);
        chk("R6 output kept after row rise", {dout_en, dout}, drv(expv[2][7]));
        addr = 4'd11; ras_n = 1'b0; tick(3);
        chk("R6 hidden refresh counted", int'(cbr_count), base + 1);
        chk("R6 hidden refresh row", int'(rfsh_row), (ROWS + 2) % ROWS);
        chk("R6 output unchanged", {dout_en, dout}, drv(expv[2][7]));
        ras_n = 1'b1; tick(3);
        chk("R6 still driven", {dout_en, dout}, drv(expv[2][7]));
        cas_high();
        chk("R6 withdrawn on cas rise", int'(dout_en), 0);

        // R7: nibble read stepping with wrap and fifth strobe reload
        nibble_en = 1'b1;
        row_open(4);
        cas_low(6, 1'b0, '0);  chk("R7 first uses addr", {dout_en, dout}, drv(expv[4][6]));  cas_high();
        cas_low(0, 1'b0, '0);  chk("R7 second step", {dout_en, dout}, drv(expv[4][7]));      cas_high();
        cas_low(0, 1'b0, '0);  chk("R7 third wraps", {dout_en, dout}, drv(expv[4][4]));      cas_high();
        cas_low(0, 1'b0, '0);  chk("R7 fourth step", {dout_en, dout}, drv(expv[4][5]));      cas_high();
        cas_low(9, 1'b0, '0);  chk("R7 fifth reloads", {dout_en, dout}, drv(expv[4][9]));    cas_high();
        row_close();
        // R7: nibble writes, addresses ignored after the first
        row_open(5);
        cas_low(13, 1'b1, 4'h1); cas_high();
        cas_low(0, 1'b1, 4'h2);  cas_high();
        cas_low(0, 1'b1, 4'h3);  cas_high();
        cas_low(0, 1'b1, 4'h4);  cas_high();
        row_close();
        nibble_en = 1'b0;
        row_open(5);
        cas_low(13, 1'b0, '0); chk("R7 write col13", {dout_en, dout}, drv(4'h1)); cas_high();
        cas_low(14, 1'b0, '0); chk("R7 write col14", {dout_en, dout}, drv(4'h2)); cas_high();
        cas_low(15, 1'b0, '0); chk("R7 write col15", {dout_en, dout}, drv(4'h3)); cas_high();
        cas_low(12, 1'b0, '0); chk("R7 write col12", {dout_en, dout}, drv(4'h4)); cas_high();
        cas_low(0, 1'b0, '0);  chk("R7 col0 untouched", {dout_en, dout}, drv(expv[5][0])); cas_high();
        row_close();

        // R8: flag clean so far, then illegal strobe during refresh
        chk("R8 no error on legal use", int'(err_flag), 0);
        cas_n = 1'b0; tick(3);
        ras_n = 1'b0; tick(3);
        cas_n = 1'b1; tick(3);
        cas_n = 1'b0; tick(3);
        chk("R8 cas fall in refresh row", int'(err_flag), 1);
        ras_n = 1'b1; tick(3);
        cas_n = 1'b1; tick(3);
        chk("R8 flag sticky", int'(err_flag), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule